// File: doc/BRIEF.md
# Precision time-of-day counter

This block keeps a running time of day, split into a seconds count and a nanoseconds count, for precision time protocol logic. On every reference clock cycle it advances the time by a nominal step, which is the reference clock period in whole nanoseconds. The nanoseconds field rolls over at one billion and carries into seconds. Time is unsigned only. Seconds simply wrap after all ones, which takes roughly 136 years.

A 32-bit fractional accumulator, counting in units of 2^-32 ns, trims the clock rate. Each cycle a programmed rate value is either added to the accumulator or taken from it, depending on a direction bit. The resulting carry adds one nanosecond to that cycle's step, and the resulting borrow removes one nanosecond. With this the time can run slightly faster or slightly slower than the reference.

A host can load a new time, set the rate value and its direction, and take a coherent snapshot of seconds and nanoseconds into shadow registers. The snapshot can then be read over several bus words while the counter keeps running.

Top module: `ptp_time_counter`

## Requirements
- R1: While `rst` is high at a clock edge, seconds, nanoseconds, both snapshot outputs, the fractional accumulator and the rate value all become zero, and the direction becomes slow (0).
- R2: With a rate value of zero and no time write, every clock edge adds `nom_inc_i` nanoseconds to the time.
- R3: When nanoseconds plus the step reaches or passes 1,000,000,000, the new nanoseconds value is that sum minus 1,000,000,000, and seconds goes up by one on the same edge. `ns_o` is never at or above 1,000,000,000.
- R4: Seconds wraps from 0xFFFFFFFF to 0 on a carry, with no other indication.
- R5: With direction 1 (faster), the rate is added to the 32-bit accumulator modulo 2^32. On a cycle where that addition carries out, the step is `nom_inc_i + 1`.
- R6: With direction 0 (slower), the rate is subtracted from the accumulator modulo 2^32. On a cycle where the accumulator is below the rate (a borrow), the step is `nom_inc_i - 1`, saturating at 0 when `nom_inc_i` is 0.
- R7: A pulse on `rate_wr_i` captures `rate_val_i` and `rate_dir_i`. The new values first take part in the update on the following edge.
- R8: A pulse on `time_wr_i` loads seconds and nanoseconds on that edge in place of the normal advance, and clears the fractional accumulator.
- R9: A written nanoseconds value at or above 1,000,000,000 is loaded as 999,999,999.
- R10: A pulse on `snap_i` copies the seconds and nanoseconds held before that edge into `snap_sec_o` and `snap_ns_o`. The snapshot outputs hold their value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| nom_inc_i | input | 8 | Nominal step per cycle, in ns |
| rate_wr_i | input | 1 | Rate value and direction load strobe |
| rate_val_i | input | 32 | Rate value, in 2^-32 ns per cycle |
| rate_dir_i | input | 1 | 1 = run faster, 0 = run slower |
| time_wr_i | input | 1 | Time load strobe |
| wr_sec_i | input | 32 | Seconds value to load |
| wr_ns_i | input | 30 | Nanoseconds value to load |
| snap_i | input | 1 | Snapshot strobe |
| sec_o | output | 32 | Live seconds |
| ns_o | output | 30 | Live nanoseconds |
| snap_sec_o | output | 32 | Snapshot seconds |
| snap_ns_o | output | 30 | Snapshot nanoseconds |

## Verification
The bench loads times a few nanoseconds below a second boundary. This shows whether the rollover leaves a value at or above one billion, or updates seconds one cycle late. It then loads all-ones seconds to confirm a silent wrap to zero. Rate values of one half and one quarter, in both directions, produce known carry and borrow patterns. A swapped direction, a lost carry, or a decrement below zero at a zero step shows up as drift within a few cycles. Snapshots taken in the same cycle as a time write must return the old time, and a rate write must change nothing on its own edge.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'b00,
    ADJ_UP   = 2'b01,
    ADJ_DOWN = 2'b10
  } adj_e;
endpackage

// File: rtl/ptp_frac_accum.sv
module ptp_frac_accum #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_wr_i,
  input  logic [FRAC_W-1:0] rate_val_i,
  input  logic              rate_dir_i,
  input  logic              clr_i,
  output ptp_tc_pkg::adj_e  adj_o
);
  logic [FRAC_W-1:0] rate_q;
  logic              dir_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   sum_up;
  logic [FRAC_W-1:0] frac_nxt;
  logic              borrow;

  always_comb begin
    sum_up   = {1'b0, frac_q} + {1'b0, rate_q};
    borrow   = frac_q < rate_q;
    frac_nxt = dir_q ? sum_up[FRAC_W-1:0] : (frac_q - rate_q);
    if (dir_q && sum_up[FRAC_W])  adj_o = ptp_tc_pkg::ADJ_UP;
    else if (!dir_q && borrow)    adj_o = ptp_tc_pkg::ADJ_DOWN;
    else                          adj_o = ptp_tc_pkg::ADJ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      dir_q  <= 1'b0;
      frac_q <= '0;
    end else begin
      if (rate_wr_i) begin
        rate_q <= rate_val_i;
        dir_q  <= rate_dir_i;
      end
      if (clr_i) frac_q <= '0;
      else       frac_q <= frac_nxt;
    end
  end
endmodule

// File: rtl/ptp_ns_sec_adv.sv
module ptp_ns_sec_adv #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int STEP_W = 9
) (
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam logic [NS_W:0] LIMIT = (NS_W+1)'(ptp_tc_pkg::NS_PER_SEC);

  logic [NS_W:0] sum;
  logic [NS_W:0] wrapped;

  always_comb begin
    sum     = {1'b0, ns_i} + (NS_W+1)'(step_i);
    wrapped = sum - LIMIT;
    if (sum >= LIMIT) begin
      ns_o  = wrapped[NS_W-1:0];
      sec_o = sec_i + 1'b1;
    end else begin
      ns_o  = sum[NS_W-1:0];
      sec_o = sec_i;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 32,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INC_W-1:0]  nom_inc_i,
  input  logic              rate_wr_i,
  input  logic [FRAC_W-1:0] rate_val_i,
  input  logic              rate_dir_i,
  input  logic              time_wr_i,
  input  logic [SEC_W-1:0]  wr_sec_i,
  input  logic [NS_W-1:0]   wr_ns_i,
  input  logic              snap_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o,
  output logic [SEC_W-1:0]  snap_sec_o,
  output logic [NS_W-1:0]   snap_ns_o
);
  localparam int STEP_W = INC_W + 1;
  localparam logic [NS_W-1:0] NS_MAX = NS_W'(ptp_tc_pkg::NS_PER_SEC - 1);

  ptp_tc_pkg::adj_e  adj;
  logic [STEP_W-1:0] step;
  logic [SEC_W-1:0]  sec_nxt;
  logic [NS_W-1:0]   ns_nxt;
  logic [NS_W-1:0]   ns_load;

  ptp_frac_accum #(.FRAC_W(FRAC_W)) u_frac (
    .clk        (clk),
    .rst        (rst),
    .rate_wr_i  (rate_wr_i),
    .rate_val_i (rate_val_i),
    .rate_dir_i (rate_dir_i),
    .clr_i      (time_wr_i),
    .adj_o      (adj)
  );

  always_comb begin
    unique case (adj)
      ptp_tc_pkg::ADJ_UP:   step = {1'b0, nom_inc_i} + 1'b1;
      ptp_tc_pkg::ADJ_DOWN: step = (nom_inc_i == '0) ? '0 : ({1'b0, nom_inc_i} - 1'b1);
      default:              step = {1'b0, nom_inc_i};
    endcase
  end

  ptp_ns_sec_adv #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W)) u_adv (
    .sec_i  (sec_o),
    .ns_i   (ns_o),
    .step_i (step),
    .sec_o  (sec_nxt),
    .ns_o   (ns_nxt)
  );

  assign ns_load = (wr_ns_i > NS_MAX) ? NS_MAX : wr_ns_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_o      <= '0;
      ns_o       <= '0;
      snap_sec_o <= '0;
      snap_ns_o  <= '0;
    end else begin
      if (snap_i) begin
        snap_sec_o <= sec_o;
        snap_ns_o  <= ns_o;
      end
      if (time_wr_i) begin
        sec_o <= wr_sec_i;
        ns_o  <= ns_load;
      end else begin
        sec_o <= sec_nxt;
        ns_o  <= ns_nxt;
      end
    end
  end
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             time_wr_i,
  input logic [SEC_W-1:0] wr_sec_i,
  input logic [NS_W-1:0]  wr_ns_i,
  input logic             snap_i,
  input logic [SEC_W-1:0] sec_o,
  input logic [NS_W-1:0]  ns_o,
  input logic [SEC_W-1:0] snap_sec_o,
  input logic [NS_W-1:0]  snap_ns_o
);
  localparam logic [NS_W-1:0] LIM = NS_W'(ptp_tc_pkg::NS_PER_SEC);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (sec_o == '0 && ns_o == '0 && snap_sec_o == '0 && snap_ns_o == '0));

  // R3
  ns_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ns_o < LIM);

  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    !time_wr_i |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1));

  // R8
  time_load_chk: assert property (@(posedge clk) disable iff (rst)
    time_wr_i |=> sec_o == $past(wr_sec_i));

  // R9
  ns_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (time_wr_i && wr_ns_i >= LIM) |=> ns_o == LIM - 1'b1);

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap_i |=> ($stable(snap_sec_o) && $stable(snap_ns_o)));

  // R10
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> (snap_sec_o == $past(sec_o) && snap_ns_o == $past(ns_o)));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .time_wr_i  (time_wr_i),
  .wr_sec_i   (wr_sec_i),
  .wr_ns_i    (wr_ns_i),
  .snap_i     (snap_i),
  .sec_o      (sec_o),
  .ns_o       (ns_o),
  .snap_sec_o (snap_sec_o),
  .snap_ns_o  (snap_ns_o)
);

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  nom_inc = 8'd0;
  logic        rate_wr = 1'b0;
  logic [31:0] rate_val = '0;
  logic        rate_dir = 1'b0;
  logic        time_wr = 1'b0;
  logic [31:0] wr_sec = '0;
  logic [29:0] wr_ns = '0;
  logic        snap = 1'b0;
  logic [31:0] sec, snap_sec;
  logic [29:0] ns, snap_ns;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  longint m_sec, m_ns, m_frac, m_rate, m_ssec, m_sns;
  bit     m_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter i_ptp_time_counter (
    .clk(clk), .rst(rst), .nom_inc_i(nom_inc), .rate_wr_i(rate_wr),
    .rate_val_i(rate_val), .rate_dir_i(rate_dir), .time_wr_i(time_wr),
    .wr_sec_i(wr_sec), .wr_ns_i(wr_ns), .snap_i(snap),
    .sec_o(sec), .ns_o(ns), .snap_sec_o(snap_sec), .snap_ns_o(snap_ns)
  );

  // Behavioural reference, evaluated once per rising edge
  always @(posedge clk) begin
    longint step, f;
    if (rst) begin
      m_sec = 0; m_ns = 0; m_frac = 0; m_rate = 0; m_dir = 0; m_ssec = 0; m_sns = 0;
    end else begin
      step = nom_inc;
      if (m_dir) begin
        f = m_frac + m_rate;
        if (f >= 64'h1_0000_0000) step = step + 1;
      end else begin
        f = m_frac - m_rate;
        if (f < 0 && step > 0) step = step - 1;
      end
      f = f & 64'hFFFF_FFFF;
      if (snap) begin m_ssec = m_sec; m_sns = m_ns; end
      if (time_wr) begin
        m_sec = wr_sec;
        m_ns  = (wr_ns >= 30'd1_000_000_000) ? 999_999_999 : wr_ns;
        m_frac = 0;
      end else begin
        m_frac = f;
        m_ns = m_ns + step;
        if (m_ns >= 1_000_000_000) begin
          m_ns  = m_ns - 1_000_000_000;
          m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
        end
      end
      if (rate_wr) begin m_rate = rate_val; m_dir = rate_dir; end
    end
  end

  task automatic compare();
    vectors++;
    if (sec !== 32'(m_sec) || ns !== 30'(m_ns) ||
        snap_sec !== 32'(m_ssec) || snap_ns !== 30'(m_sns)) begin
      miscompares++;
      $display("FAIL %s: sec=%0d ns=%0d snap=%0d/%0d expected sec=%0d ns=%0d snap=%0d/%0d",
               cur_req, sec, ns, snap_sec, snap_ns, m_sec, m_ns, m_ssec, m_sns);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic load_time(logic [31:0] s, logic [29:0] n);
    wr_sec = s; wr_ns = n; time_wr = 1'b1;
    cyc();
    time_wr = 1'b0;
  endtask

  task automatic set_rate(logic [31:0] v, logic d);
    rate_val = v; rate_dir = d; rate_wr = 1'b1;
    cyc();
    rate_wr = 1'b0;
  endtask

  task automatic take_snap();
    snap = 1'b1;
    cyc();
    snap = 1'b0;
  endtask

  initial begin
    // R1: reset state
    cyc(2);
    rst = 1'b0;
    nom_inc = 8'd8;
    // R2: plain nominal advance
    cur_req = "R2";
    cyc(20);
    // R8 and R3: load near a second boundary and cross it
    cur_req = "R8";
    load_time(32'd5, 30'd999_999_990);
    cur_req = "R3";
    cyc(6);
    // R4: seconds wraps from all ones
    cur_req = "R4";
    load_time(32'hFFFF_FFFF, 30'd999_999_995);
    cyc(3);
    // R9: clamp of an out-of-range write
    cur_req = "R9";
    load_time(32'd77, 30'h3FFF_FFFF);
    load_time(32'd78, 30'd1_000_000_000);
    cyc(2);
    // R7: rate write has no effect on its own edge
    cur_req = "R7";
    set_rate(32'h8000_0000, 1'b1);
    // R5: faster, carry every second cycle, then every fourth
    cur_req = "R5";
    cyc(10);
    set_rate(32'h4000_0000, 1'b1);
    cyc(12);
    // R8: write clears the accumulator mid-run
    cur_req = "R8";
    load_time(32'd100, 30'd999_999_900);
    cyc(20);
    // R6: slower, borrow pattern, then saturation at a zero step
    cur_req = "R6";
    set_rate(32'h4000_0000, 1'b0);
    cyc(12);
    nom_inc = 8'd0;
    cyc(8);
    nom_inc = 8'd1;
    set_rate(32'hC000_0000, 1'b0);
    cyc(8);
    nom_inc = 8'd255;
    cyc(4);
    // R10: snapshot while running, hold, and same-cycle write
    cur_req = "R10";
    take_snap();
    cyc(5);
    wr_sec = 32'd9; wr_ns = 30'd1234; time_wr = 1'b1; snap = 1'b1;
    cyc();
    time_wr = 1'b0; snap = 1'b0;
    cyc(3);
    take_snap();
    cyc(2);
    // R1: reset mid-run clears everything including the rate
    cur_req = "R1";
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    nom_inc = 8'd8;
    cyc(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule